// File: doc/BRIEF.md
# RGB Component Curve Table

This block sits in the RGB stage of a pixel pipeline and remaps each colour component through its own 256-entry, 8-bit table. There is one table for red, one for green and one for blue. The usual use is gamma correction, but any monotonic or arbitrary curve can be held. Each pixel comes out one clock after it enters, and the valid and sync flags are delayed to match. A bypass control sends pixels through unchanged with the same latency.

The tables can be filled in two ways. The first is a host write port that carries a channel select, an address and a data byte. The second is an in-band load mode. While `load_mode` is high, each valid pixel word writes its red, green and blue fields into the same entry of the three tables. The entry index starts at zero and steps by one per word. Host writes are refused while in-band loading is active. Table contents are undefined after reset until they are loaded.

Top module: `rgb_curve_lut`

## Requirements
- R1: During and right after reset, `out_valid`, `out_hsync`, `out_vsync`, `out_r`, `out_g` and `out_b` are all zero.
- R2: With `load_mode` and `bypass` low, a pixel presented at a clock edge appears on the outputs after that edge as red table[`in_r`], green table[`in_g`], blue table[`in_b`].
- R3: `out_hsync` and `out_vsync` equal `in_hsync` and `in_vsync` from one clock earlier. `out_valid` is high exactly when, one clock earlier, `in_valid` was high and `load_mode` was low.
- R4: While `load_mode` is high, the k-th valid word since `load_mode` rose writes `in_r`, `in_g` and `in_b` into entry k mod 256 of the red, green and blue tables. Cycles with `in_valid` low do not advance k.
- R5: Any clock edge taken with `load_mode` high gives `out_valid` low after it.
- R6: With `bypass` high and `load_mode` low, each output component equals the matching input component from one clock earlier.
- R7: A host write with `host_we` high and `load_mode` low stores `host_data` at entry `host_addr`. `host_sel` chooses the table: 0 red, 1 green, 2 blue, 3 all three.
- R8: A host write made while `load_mode` is high leaves every table unchanged.
- R9: If a pixel looks up an entry in the same cycle that a host write changes that entry, the pixel gets the old value. Pixels entering from the next cycle on get the new value.
- R10: Each time `load_mode` goes low and then high again, the in-band index starts over at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset of the pipeline and the load index |
| load_mode | input | 1 | In-band table load via the pixel port |
| bypass | input | 1 | Pass components through untranslated |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Table select: 0 red, 1 green, 2 blue, 3 all |
| host_addr | input | 8 | Host entry address |
| host_data | input | 8 | Host entry value |
| in_valid | input | 1 | Input pixel valid |
| in_hsync | input | 1 | Input horizontal sync |
| in_vsync | input | 1 | Input vertical sync |
| in_r | input | 8 | Input red component |
| in_g | input | 8 | Input green component |
| in_b | input | 8 | Input blue component |
| out_valid | output | 1 | Output pixel valid |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_r | output | 8 | Output red component |
| out_g | output | 8 | Output green component |
| out_b | output | 8 | Output blue component |

## Verification
The assertions assume that `load_mode` and `bypass` are clean levels, sampled at each clock edge like the pixel inputs. They also assume that output colour data matters only while `out_valid` is high, since the component registers update on every cycle. The stimulus drives every input a short time after the rising edge, so each level is settled well before the next edge. It then samples the outputs at that same point. Colours are checked only on cycles where a valid pixel is expected, and the first output check waits until all three tables have been filled with known values.

// File: rtl/rgb_curve_lut.sv
module rgb_curve_lut #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_mode,
  input  logic          bypass,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  input  logic [CW-1:0] host_addr,
  input  logic [CW-1:0] host_data,
  input  logic          in_valid,
  input  logic          in_hsync,
  input  logic          in_vsync,
  input  logic [CW-1:0] in_r,
  input  logic [CW-1:0] in_g,
  input  logic [CW-1:0] in_b,
  output logic          out_valid,
  output logic          out_hsync,
  output logic          out_vsync,
  output logic [CW-1:0] out_r,
  output logic [CW-1:0] out_g,
  output logic [CW-1:0] out_b
);
  localparam int DEPTH = 1 << CW;

  logic [CW-1:0] tab_r [DEPTH];
  logic [CW-1:0] tab_g [DEPTH];
  logic [CW-1:0] tab_b [DEPTH];
  logic [CW-1:0] fill_ptr;

  wire fill_hit = load_mode & in_valid;
  wire host_ok  = host_we & ~load_mode;
  wire wr_r = host_ok & (host_sel == 2'd0 || host_sel == 2'd3);
  wire wr_g = host_ok & (host_sel == 2'd1 || host_sel == 2'd3);
  wire wr_b = host_ok & (host_sel == 2'd2 || host_sel == 2'd3);

  always_ff @(posedge clk) begin
    if (fill_hit) begin
      tab_r[fill_ptr] <= in_r;
      tab_g[fill_ptr] <= in_g;
      tab_b[fill_ptr] <= in_b;
    end else begin
      if (wr_r) tab_r[host_addr] <= host_data;
      if (wr_g) tab_g[host_addr] <= host_data;
      if (wr_b) tab_b[host_addr] <= host_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fill_ptr <= '0;
    else if (!load_mode) fill_ptr <= '0;
    else if (in_valid)   fill_ptr <= fill_ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hsync <= 1'b0;
      out_vsync <= 1'b0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= in_valid & ~load_mode;
      out_hsync <= in_hsync;
      out_vsync <= in_vsync;
      out_r     <= bypass ? in_r : tab_r[in_r];
      out_g     <= bypass ? in_g : tab_g[in_g];
      out_b     <= bypass ? in_b : tab_b[in_b];
    end
  end

  assert_load_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_mode |=> !out_valid);

  assert_valid_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !load_mode) |=> out_valid);

  assert_sync_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hsync && !in_vsync) |=> (out_hsync && !out_vsync));

  assert_bypass_same_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !load_mode) |=> (out_r == $past(in_r) && out_g == $past(in_g) && out_b == $past(in_b)));

  assert_fill_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_mode && in_valid) |=> (!load_mode || fill_ptr == $past(fill_ptr) + 1'b1));

  assert_fill_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_mode |=> (fill_ptr == '0));
endmodule

// File: tb/rgb_curve_lut_bench.sv
module rgb_curve_lut_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_mode = 0, bypass = 0, host_we = 0;
  logic [1:0] host_sel = 0;
  logic [7:0] host_addr = 0, host_data = 0;
  logic in_valid = 0, in_hsync = 0, in_vsync = 0;
  logic [7:0] in_r = 0, in_g = 0, in_b = 0;
  logic out_valid, out_hsync, out_vsync;
  logic [7:0] out_r, out_g, out_b;

  int total = 0, bad = 0;
  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  int idx = 0;

  always #10 clk = ~clk;

  rgb_curve_lut u_rgb_curve_lut (
    .clk, .rst_n, .load_mode, .bypass, .host_we, .host_sel, .host_addr, .host_data,
    .in_valid, .in_hsync, .in_vsync, .in_r, .in_g, .in_b,
    .out_valid, .out_hsync, .out_vsync, .out_r, .out_g, .out_b);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] xlate(logic byp, logic [7:0] r, logic [7:0] g, logic [7:0] b);
    return byp ? {r, g, b} : {mr[r], mg[g], mb[b]};
  endfunction

  task automatic step(string tag, logic lm, logic byp, logic v, logic hs, logic vs,
                      logic [7:0] r, logic [7:0] g, logic [7:0] b,
                      logic hwe, logic [1:0] hsel, logic [7:0] ha, logic [7:0] hd);
    logic [23:0] expc;
    load_mode = lm; bypass = byp; in_valid = v; in_hsync = hs; in_vsync = vs;
    in_r = r; in_g = g; in_b = b;
    host_we = hwe; host_sel = hsel; host_addr = ha; host_data = hd;
    expc = xlate(byp, r, g, b);
    @(posedge clk); #1;
    chk({tag, " R3 valid"}, out_valid, v && !lm);
    chk({tag, " R3 sync"}, {out_hsync, out_vsync}, {hs, vs});
    if (lm) chk({tag, " R5 blank"}, out_valid, 0);
    if (v && !lm) chk({tag, byp ? " R6 bypass" : " R2 xlate"}, {out_r, out_g, out_b}, expc);
    if (!lm) begin
      idx = 0;
      if (hwe) begin
        if (hsel == 0 || hsel == 3) mr[ha] = hd;
        if (hsel == 1 || hsel == 3) mg[ha] = hd;
        if (hsel == 2 || hsel == 3) mb[ha] = hd;
      end
    end else if (v) begin
      mr[idx] = r; mg[idx] = g; mb[idx] = b;
      idx = (idx + 1) % 256;
    end
  endtask

  task automatic idle(logic lm);
    step("idle", lm, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic probe(string tag, logic [7:0] a);
    step(tag, 0, 0, 1, 0, 0, a, a, a, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #5;
    chk("R1 reset", {out_valid, out_hsync, out_vsync, out_r, out_g, out_b}, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset held", {out_valid, out_hsync, out_vsync, out_r, out_g, out_b}, 0);
    rst_n = 1'b1;

    // R4 ramp load with gaps
    for (int i = 0; i < 256; i++) begin
      step("R4 load", 1, 0, 1, i[0], 0, i[7:0], 8'(255 - i), i[7:0] ^ 8'h5a, 0, 0, 0, 0);
      if (i % 37 == 0) idle(1);
    end
    idle(0);
    for (int a = 0; a < 256; a += 51) begin
      probe("R4 ramp", a[7:0]);
      chk("R4 ramp content", {out_r, out_g, out_b}, {a[7:0], 8'(255 - a), a[7:0] ^ 8'h5a});
    end

    // R2/R3 random normal traffic
    for (int i = 0; i < 300; i++)
      step("rand", 0, 0, 1'($urandom), 1'($urandom), 1'($urandom),
           8'($urandom), 8'($urandom), 8'($urandom), 0, 0, 0, 0);

    // R7 host writes mixed with traffic
    for (int i = 0; i < 200; i++)
      step("R7 host", 0, 0, 1, 0, 0, 8'($urandom), 8'($urandom), 8'($urandom),
           1, 2'($urandom), 8'($urandom), 8'($urandom));
    for (int i = 0; i < 256; i++) probe("R7 readback", i[7:0]);

    // R9 same-cycle collision
    step("R9 collide", 0, 0, 1, 0, 0, 8'd40, 8'd40, 8'd40, 1, 3, 8'd40, 8'hc3);
    probe("R9 after", 8'd40);
    chk("R9 new value", out_r, 8'hc3);

    // R8 host write ignored during load mode
    idle(1);
    step("R8 blocked", 1, 0, 0, 0, 0, 0, 0, 0, 1, 3, 8'd77, ~mr[77]);
    idle(0);
    probe("R8 unchanged", 8'd77);

    // R4 wrap: 258 words
    for (int i = 0; i < 258; i++)
      step("R4 wrap", 1, 0, 1, 0, 1, 8'(i * 3), 8'(i + 9), 8'(~i), 0, 0, 0, 0);
    idle(0);
    probe("R4 wrap e0", 8'd0);
    chk("R4 wrap e0 val", out_r, 8'(256 * 3));
    probe("R4 wrap e1", 8'd1);
    probe("R4 wrap e255", 8'd255);

    // R10 restart
    for (int i = 0; i < 3; i++)
      step("R10 load", 1, 0, 1, 0, 0, 8'(200 + i), 8'(100 + i), 8'(50 + i), 0, 0, 0, 0);
    idle(0);
    probe("R10 e0", 8'd0);
    chk("R10 e0 val", out_b, 8'd50);
    probe("R10 e2", 8'd2);
    probe("R10 e3", 8'd3);

    // R6 bypass
    for (int i = 0; i < 100; i++)
      step("R6", 0, 1, 1, 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 0, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule